// File: doc/BRIEF.md
# Byte Pop-Out Output Staging Register

This block sits between a cipher engine and a host bus. The engine hands over a finished 64-bit result word in parallel. The host then drains it one byte per read strobe, like pop-up storage: the most significant remaining byte comes out first, and the contents shift up behind it. A byte counter tracks how many result bytes are still unread.

The register reports full while even a single byte is left, and it reports empty only once every byte has been read. The engine may load a new word only while the register is empty. How many bytes such a load makes valid depends on the mode:

- A block mode makes all eight bytes valid.
- A feedback mode makes a single byte valid.

A host read of an empty register does not drive the data bus. This is modelled as a low data-enable, with the data lines held at zero.

Top module: `byte_popout_stage`

## Requirements
- R1: After reset the byte count is 0, `full` is 0 and `rd_drive` is 0.
- R2: The byte count never exceeds 8, and `full` is 1 exactly when the count is nonzero.
- R3: A read strobe while `full` is 1 raises `rd_drive` in that same cycle and presents the most significant remaining byte on `rd_data`. On the next clock edge the contents shift left by 8 bits and the count drops by one.
- R4: In block mode (`mode_sel` = 0), a load accepted while empty sets the count to 8. The bytes are then read out in the order `load_data[63:56]` first, down to `load_data[7:0]` last.
- R5: In feedback mode (`mode_sel` = 1), a load accepted while empty sets the count to 1. The single byte then read is `load_data[7:0]`.
- R6: While the count is nonzero, a load request is refused: `load_accept` is 0, and both the stored bytes and the count are left unchanged.
- R7: A read strobe while empty gives `rd_drive` = 0 and `rd_data` = 0, and the count stays 0.
- R8: Reading the last remaining byte makes the register empty on the next cycle, and a load offered after that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Engine offers a result word |
| load_data | input | 64 | Result word from the engine |
| mode_sel | input | 1 | 0 = block mode (8 bytes), 1 = feedback mode (1 byte) |
| load_accept | output | 1 | Load taken this cycle |
| rd_en | input | 1 | Host read strobe, one byte per cycle |
| rd_data | output | 8 | Byte presented to the host |
| rd_drive | output | 1 | Data-enable; low means the bus is left undriven |
| full | output | 1 | At least one byte is still unread |
| byte_cnt | output | 4 | Number of unread bytes |

## Verification
Block loads use several distinct bytes, all-ones words and alternating words. A byte-order or shift-direction error shows up as misplaced bytes. Feedback loads carry different upper and lower bytes, which shows whether the low byte is the one kept. Loads offered while partially drained show whether a refused load corrupts the stored word. Reads of an empty register, interleaved with these loads, separate a data-enable held low from stale bytes leaking out.

// File: rtl/byte_popout_pkg.sv
package byte_popout_pkg;
  typedef enum logic {
    MODE_BLOCK    = 1'b0,
    MODE_FEEDBACK = 1'b1
  } pop_mode_e;
endpackage

// File: rtl/byte_popout_counter.sv
module byte_popout_counter #(
  parameter int NBYTES = 8,
  localparam int CNT_W = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             pop_fire,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_fire | pop_fire;
    cnt_d  = cnt_q;
    if (load_fire)     cnt_d = load_cnt;
    else if (pop_fire) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NBYTES));

  a_r3_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !load_fire) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/byte_popout_store.sv
module byte_popout_store #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic              narrow,
  input  logic [DATA_W-1:0] load_data,
  input  logic              pop_fire,
  output logic [BYTE_W-1:0] top_byte
);
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    data_en = load_fire | pop_fire;
    data_d  = data_q;
    if (load_fire) begin
      if (narrow) data_d = {load_data[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
      else        data_d = load_data;
    end else if (pop_fire) begin
      data_d = {data_q[DATA_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign top_byte = data_q[DATA_W-1 -: BYTE_W];

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && !load_fire) |=> (top_byte == $past(data_q[DATA_W-BYTE_W-1 -: BYTE_W])));
endmodule

// File: rtl/byte_popout_readport.sv
module byte_popout_readport #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              have_byte,
  input  logic [BYTE_W-1:0] top_byte,
  output logic              pop_fire,
  output logic              rd_drive,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    pop_fire = rd_en & have_byte;
    rd_drive = pop_fire;
    rd_data  = pop_fire ? top_byte : '0;
  end

  a_r7_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive |-> (rd_data == '0));
endmodule

// File: rtl/byte_popout_stage.sv
module byte_popout_stage #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NBYTES = DATA_W / BYTE_W,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  input  logic              mode_sel,
  output logic              load_accept,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              full,
  output logic [CNT_W-1:0]  byte_cnt
);
  import byte_popout_pkg::*;

  pop_mode_e        mode;
  logic             narrow;
  logic [CNT_W-1:0] load_cnt;
  logic             pop_fire;
  logic [BYTE_W-1:0] top_byte;

  always_comb begin
    mode        = pop_mode_e'(mode_sel);
    narrow      = (mode == MODE_FEEDBACK);
    load_cnt    = narrow ? CNT_W'(1) : CNT_W'(NBYTES);
    full        = (byte_cnt != '0);
    load_accept = load_valid & ~full;
  end

  byte_popout_counter #(.NBYTES(NBYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_fire(load_accept), .load_cnt(load_cnt),
    .pop_fire(pop_fire), .cnt_q(byte_cnt));

  byte_popout_store #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load_fire(load_accept), .narrow(narrow),
    .load_data(load_data), .pop_fire(pop_fire), .top_byte(top_byte));

  byte_popout_readport #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .have_byte(full),
    .top_byte(top_byte), .pop_fire(pop_fire), .rd_drive(rd_drive),
    .rd_data(rd_data));

  a_r6_refuse_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && byte_cnt != '0) |-> !load_accept);

  a_r7_no_drive_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && byte_cnt == '0) |-> !rd_drive);

  a_r4_block_count: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && !mode_sel) |=> (byte_cnt == CNT_W'(NBYTES)));

  a_r5_feedback_count: assert property (@(posedge clk) disable iff (!rst_n)
    (load_accept && mode_sel) |=> (byte_cnt == CNT_W'(1)));

  a_r8_last_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && byte_cnt == CNT_W'(1)) |=> !full);
endmodule

// File: tb/byte_popout_stage_tb.sv
module byte_popout_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_valid, mode_sel, rd_en;
  logic [63:0] load_data;
  logic        load_accept, rd_drive, full;
  logic [7:0]  rd_data;
  logic [3:0]  byte_cnt;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  byte_popout_stage u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .mode_sel(mode_sel), .load_accept(load_accept), .rd_en(rd_en),
    .rd_data(rd_data), .rd_drive(rd_drive), .full(full), .byte_cnt(byte_cnt));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected bytes on every read strobe (R3, R7).
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check("R3 drive", {63'd0, rd_drive}, 64'd1);
        check("R3 R4 R5 byte", {56'd0, rd_data}, {56'd0, e});
      end else begin
        check("R7 drive", {63'd0, rd_drive}, 64'd0);
        check("R7 data", {56'd0, rd_data}, 64'd0);
      end
    end
  end

  // Driver: offers one load and pushes expected bytes if it should be taken.
  task automatic do_load(input logic [63:0] d, input logic m);
    bit take;
    @(posedge clk); #1;
    load_valid = 1'b1; load_data = d; mode_sel = m;
    take = (exp_q.size() == 0);
    @(negedge clk);
    check(take ? "R8 accept" : "R6 refuse", {63'd0, load_accept}, {63'd0, take});
    if (take) begin
      if (m) exp_q.push_back(d[7:0]);
      else for (int i = 7; i >= 0; i--) exp_q.push_back(d[i*8 +: 8]);
    end
    @(posedge clk); #1;
    load_valid = 1'b0;
    @(negedge clk);
    check("R2 R4 R5 count", {60'd0, byte_cnt}, exp_q.size());
    check("R2 full", {63'd0, full}, {63'd0, exp_q.size() != 0});
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rd_en = 1'b1;
    end
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
    check("R2 R8 count after reads", {60'd0, byte_cnt}, exp_q.size());
    check("R8 full after reads", {63'd0, full}, {63'd0, exp_q.size() != 0});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_valid = 1'b0; mode_sel = 1'b0; rd_en = 1'b0; load_data = '0;
    #12; rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", {60'd0, byte_cnt}, 64'd0);
    check("R1 full", {63'd0, full}, 64'd0);
    check("R1 drive", {63'd0, rd_drive}, 64'd0);
    do_reads(2);                                   // R7 empty reads
    do_load(64'h0123_4567_89AB_CDEF, 1'b0);        // R4
    do_reads(8);                                   // R8 empties
    do_load(64'hFFEE_DDCC_BBAA_995A, 1'b1);        // R5 low byte kept
    do_load(64'h1111_1111_1111_1111, 1'b0);        // R6 refused
    do_reads(1);
    do_load(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    do_reads(3);
    do_load(64'hAA55_AA55_AA55_AA55, 1'b1);        // R6 partial drain refused
    do_reads(6);                                   // last is empty read (R7)
    do_load(64'h55AA_55AA_0F0F_F0F0, 1'b0);
    do_reads(2);
    rst_n = 1'b0; exp_q.delete(); #7; rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", {60'd0, byte_cnt}, 64'd0);
    do_load(64'h8877_6655_4433_2211, 1'b1);
    do_reads(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule